// File: doc/BRIEF.md
# Merging Posted Write Buffer

This block sits between a processor store port and a main-memory write port. Each store arrives with a byte address, 32-bit data, per-byte strobes and two attributes: bufferable and cachable. Bufferable stores are posted into a short queue and acknowledged at once. A later bufferable store to a word that is already queued, but not yet offered to memory, is folded into that entry, so memory sees one write instead of two. Non-bufferable stores, for example to I/O registers, skip the queue. They are held in a single slot and reach memory only after every older posted write has gone out. Other stores wait until that slot has emptied.

Faults are reported on two separate paths. A store whose address lies at or above a configured limit, or that enables no byte, is refused with an abort pulse when it is accepted. An error returned by memory when a posted write later retires cannot be tied to the store that caused it. It therefore raises a sticky interrupt and records the word address of the failing write. A drain handshake lets software push every pending write out to memory before it changes page tables or shares a buffer with another bus master.

Top module: `post_wbuf`

## Requirements
- R1: After reset, req_ready_o is 1 and mem_valid_o, abort_o, irq_o and drain_done_o are 0.
- R2: Posted writes go to memory oldest first, one per mem_valid_o/mem_ready_i handshake. mem_addr_o carries the word address with bits [1:0] forced to zero. Address, data and strobes stay stable while mem_valid_o is high and mem_ready_i is low.
- R3: A bufferable store merges into a queued entry that is not the one being offered to memory when both have the same word address and the same cachable bit. Enabled bytes of the new store replace the old bytes, and the strobes are ORed. Memory then receives a single write. The entry at the head of the queue never merges.
- R4: With all DEPTH entries occupied, req_ready_o is 0 for a bufferable store that would need a new entry. It is 1 for a store that merges into an entry.
- R5: A non-bufferable store is never merged. It is presented to memory only when the queue is empty. While it waits, req_ready_o is 0 for every store.
- R6: A store with address >= LIMIT (0x1000_0000 by default), or with all strobes zero, is accepted and dropped. abort_o is 1 in the cycle after acceptance. A legal store leaves abort_o at 0.
- R7: mem_err_i high during a handshake sets irq_o on the next cycle and loads err_addr_o with that write's mem_addr_o. abort_o is not raised.
- R8: irq_o stays 1 until irq_clr_i is pulsed. If a new error and a clear arrive in the same cycle, the error wins.
- R9: While drain_req_i is 1, req_ready_o is 0. drain_done_o is 1 exactly when drain_req_i is 1 and neither the queue nor the non-bufferable slot holds a write.
- R10: The cachable bit of each store appears on mem_cache_o with its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Store request valid |
| req_ready_o | output | 1 | Store accepted when high with valid |
| req_addr_i | input | 32 | Store byte address |
| req_data_i | input | 32 | Store data |
| req_strb_i | input | 4 | Byte enables, bit n for data[8n+7:8n] |
| req_buf_i | input | 1 | 1 = bufferable store |
| req_cache_i | input | 1 | 1 = cachable store |
| abort_o | output | 1 | Pulse one cycle after an illegal store is accepted |
| mem_valid_o | output | 1 | Memory write valid |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_data_o | output | 32 | Memory write data |
| mem_strb_o | output | 4 | Memory byte enables |
| mem_cache_o | output | 1 | Cachable attribute of the write |
| mem_err_i | input | 1 | Error for the write in the current handshake |
| drain_req_i | input | 1 | Drain request, held high |
| drain_done_o | output | 1 | All pending writes completed during a drain |
| irq_o | output | 1 | Sticky memory write error interrupt |
| irq_clr_i | input | 1 | Clear pulse for irq_o |
| err_addr_o | output | 32 | Address of the last failing write |

## Verification
The assertions guard properties that hold on every cycle. The queue never allocates past its depth and never pops while empty. A merge leaves the occupancy unchanged. The memory port holds steady under backpressure, and the non-bufferable slot empties only through a handshake. Every abort follows an acceptance, the interrupt stays set until it is cleared, and drain completion never coincides with a pending memory write. The bench scenarios are needed for the rest. They show which entry a store merges into and the byte-level result of that merge, the ordering of a non-bufferable store against older posted writes, stalling when the queue is full and the exception made for a merge hit, and that error and clear meeting in the same cycle leaves the interrupt set.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned WB_AW = 32;
  parameter int unsigned WB_DW = 32;
  localparam int unsigned WB_SW = WB_DW / 8;
  localparam int unsigned WB_OW = $clog2(WB_SW);
  localparam int unsigned WB_WW = WB_AW - WB_OW;

  typedef struct packed {
    logic [WB_WW-1:0] waddr;
    logic [WB_DW-1:0] data;
    logic [WB_SW-1:0] strb;
    logic             cache;
  } wb_ent_t;
endpackage

// File: rtl/wbuf_addr_chk.sv
module wbuf_addr_chk
  import wbuf_pkg::*;
#(
  parameter logic [WB_AW-1:0] LIMIT = 32'h1000_0000
) (
  input  logic [WB_AW-1:0] addr_i,
  input  logic [WB_SW-1:0] strb_i,
  output logic             bad_o
);
  // only faults visible at acceptance time are reported
  assign bad_o = (addr_i >= LIMIT) || (strb_i == '0);
endmodule

// File: rtl/wbuf_queue.sv
module wbuf_queue
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  wb_ent_t push_ent_i,
  input  logic    pop_i,
  output logic    hit_o,
  output logic    full_o,
  output logic    empty_o,
  output wb_ent_t head_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  wb_ent_t          ent_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] hit_vec;
  logic             alloc;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [CW-1:0] rel;
    // distance from head, head itself excluded from merging
    assign rel = (CW'(i) >= CW'(head_q)) ? (CW'(i) - CW'(head_q))
                                          : (CW'(DEPTH) - CW'(head_q) + CW'(i));
    assign hit_vec[i] = (rel < cnt_q) && (rel != '0) &&
                        (ent_q[i].waddr == push_ent_i.waddr) &&
                        (ent_q[i].cache == push_ent_i.cache);
  end

  assign hit_o   = |hit_vec;
  assign alloc   = push_i & ~hit_o;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = ent_q[head_q];

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_i) head_q <= inc_ptr(head_q);
      if (alloc) tail_q <= inc_ptr(tail_q);
      cnt_q <= cnt_q + CW'(alloc) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc && tail_q == PW'(i)) begin
        ent_q[i] <= push_ent_i;
      end else if (push_i && hit_vec[i]) begin
        for (int b = 0; b < WB_SW; b++) begin
          if (push_ent_i.strb[b]) ent_q[i].data[8*b +: 8] <= push_ent_i.data[8*b +: 8];
        end
        ent_q[i].strb <= ent_q[i].strb | push_ent_i.strb;
      end
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |-> !full_o);
  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_merge_no_grow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && hit_o && !pop_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/wbuf_err.sv
module wbuf_err
  import wbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [WB_AW-1:0] addr_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [WB_AW-1:0] err_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      err_addr_o <= '0;
    end else if (set_i) begin  // set wins over clear
      irq_o      <= 1'b1;
      err_addr_o <= addr_i;
    end else if (clr_i) begin
      irq_o <= 1'b0;
    end
  end

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_i));
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf
  import wbuf_pkg::*;
#(
  parameter int unsigned      DEPTH = 4,
  parameter logic [WB_AW-1:0] LIMIT = 32'h1000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [WB_AW-1:0] req_addr_i,
  input  logic [WB_DW-1:0] req_data_i,
  input  logic [WB_SW-1:0] req_strb_i,
  input  logic             req_buf_i,
  input  logic             req_cache_i,
  output logic             abort_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [WB_AW-1:0] mem_addr_o,
  output logic [WB_DW-1:0] mem_data_o,
  output logic [WB_SW-1:0] mem_strb_o,
  output logic             mem_cache_o,
  input  logic             mem_err_i,
  input  logic             drain_req_i,
  output logic             drain_done_o,
  output logic             irq_o,
  input  logic             irq_clr_i,
  output logic [WB_AW-1:0] err_addr_o
);
  wb_ent_t new_ent, head_ent, byp_q, out_ent;
  logic    bad, q_hit, q_full, q_empty, q_push, q_pop;
  logic    byp_vld_q, byp_load, take, acc, hs;

  assign new_ent = '{waddr: req_addr_i[WB_AW-1:WB_OW], data: req_data_i,
                     strb: req_strb_i, cache: req_cache_i};

  wbuf_addr_chk #(.LIMIT(LIMIT)) u_chk (
    .addr_i (req_addr_i),
    .strb_i (req_strb_i),
    .bad_o  (bad)
  );

  wbuf_queue #(.DEPTH(DEPTH)) u_q (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (q_push),
    .push_ent_i (new_ent),
    .pop_i      (q_pop),
    .hit_o      (q_hit),
    .full_o     (q_full),
    .empty_o    (q_empty),
    .head_o     (head_ent)
  );

  // a held uncached store blocks everything behind it
  assign take = ~drain_req_i & ~byp_vld_q &
                (bad | ~req_buf_i | ~q_full | q_hit);
  assign req_ready_o = take;
  assign acc      = req_valid_i & take;
  assign q_push   = acc & ~bad & req_buf_i;
  assign byp_load = acc & ~bad & ~req_buf_i;

  // uncached slot goes out only behind an empty queue
  assign out_ent     = q_empty ? byp_q : head_ent;
  assign mem_valid_o = ~q_empty | byp_vld_q;
  assign mem_addr_o  = {out_ent.waddr, {WB_OW{1'b0}}};
  assign mem_data_o  = out_ent.data;
  assign mem_strb_o  = out_ent.strb;
  assign mem_cache_o = out_ent.cache;
  assign hs          = mem_valid_o & mem_ready_i;
  assign q_pop       = hs & ~q_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_vld_q <= 1'b0;
      byp_q     <= '0;
      abort_o   <= 1'b0;
    end else begin
      abort_o <= acc & bad;
      if (byp_load) begin
        byp_vld_q <= 1'b1;
        byp_q     <= new_ent;
      end else if (hs && q_empty) begin
        byp_vld_q <= 1'b0;
      end
    end
  end

  assign drain_done_o = drain_req_i & q_empty & ~byp_vld_q;

  wbuf_err u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hs & mem_err_i),
    .addr_i     (mem_addr_o),
    .clr_i      (irq_clr_i),
    .irq_o      (irq_o),
    .err_addr_o (err_addr_o)
  );

  p_mem_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) &&
                                        $stable(mem_data_o) && $stable(mem_strb_o)));
  p_byp_leaves_on_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byp_vld_q) |-> $past(mem_valid_o && mem_ready_i && q_empty));
  p_abort_after_acc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(req_valid_i && req_ready_o));
  p_drain_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done_o |-> !mem_valid_o);
endmodule

// File: tb/tb_post_wbuf.sv
module tb_post_wbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 0, req_buf_i = 0, req_cache_i = 0;
  logic [31:0] req_addr_i = '0, req_data_i = '0;
  logic [3:0]  req_strb_i = '0;
  logic        req_ready_o, abort_o, mem_valid_o, mem_cache_o;
  logic        mem_ready_i = 0, mem_err_i = 0, drain_req_i = 0, irq_clr_i = 0;
  logic [31:0] mem_addr_o, mem_data_o, err_addr_o;
  logic [3:0]  mem_strb_o;
  logic        drain_done_o, irq_o;

  int n_vec = 0, n_fail = 0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  s;
    logic        c;
  } mexp_t;
  mexp_t exp_q[$];
  mexp_t e;

  always #4 clk = ~clk;

  post_wbuf dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .req_data_i(req_data_i), .req_strb_i(req_strb_i), .req_buf_i(req_buf_i),
    .req_cache_i(req_cache_i), .abort_o(abort_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .mem_strb_o(mem_strb_o), .mem_cache_o(mem_cache_o),
    .mem_err_i(mem_err_i), .drain_req_i(drain_req_i), .drain_done_o(drain_done_o),
    .irq_o(irq_o), .irq_clr_i(irq_clr_i), .err_addr_o(err_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expm(input logic [31:0] a, d, input logic [3:0] s, input logic c);
    mexp_t m;
    m.a = a; m.d = d; m.s = s; m.c = c;
    exp_q.push_back(m);
  endtask

  // driver: holds the store until accepted
  task automatic wr(input logic [31:0] a, d, input logic [3:0] s, input logic b, c);
    @(posedge clk); #1;
    req_valid_i = 1; req_addr_i = a; req_data_i = d; req_strb_i = s;
    req_buf_i = b; req_cache_i = c;
    do @(negedge clk); while (!req_ready_o);
    @(posedge clk); #1;
    req_valid_i = 0;
  endtask

  task automatic set_rdy(input logic v);
    @(posedge clk); #1;
    mem_ready_i = v;
  endtask

  task automatic wait_empty(input string tag);
    for (int k = 0; k < 60 && (exp_q.size() != 0 || mem_valid_o); k++) @(negedge clk);
    chk(exp_q.size() == 0 && !mem_valid_o, tag, exp_q.size(), 0);
  endtask

  // monitor: compares each memory handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_valid_o && mem_ready_i) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 R6 unexpected write: actual=%h/%h expected=none", mem_addr_o, mem_data_o);
      end else begin
        e = exp_q.pop_front();
        if (mem_addr_o !== e.a || mem_data_o !== e.d || mem_strb_o !== e.s || mem_cache_o !== e.c) begin
          n_fail++;
          $display("FAIL R2 R3 R5 R10 write: actual=%h/%h/%h/%b expected=%h/%h/%h/%b",
                   mem_addr_o, mem_data_o, mem_strb_o, mem_cache_o, e.a, e.d, e.s, e.c);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready_o === 1'b1, "R1 ready", req_ready_o, 1);
    chk(mem_valid_o === 1'b0, "R1 mem_valid", mem_valid_o, 0);
    chk(abort_o === 1'b0, "R1 abort", abort_o, 0);
    chk(irq_o === 1'b0, "R1 irq", irq_o, 0);
    chk(drain_done_o === 1'b0, "R1 drain_done", drain_done_o, 0);

    // R2 R10: in-order retire, word alignment, cache bit
    set_rdy(1);
    expm(32'h100, 32'h1111_1111, 4'hF, 1'b1);
    expm(32'h204, 32'h2222_2222, 4'h3, 1'b0);
    wr(32'h100, 32'h1111_1111, 4'hF, 1, 1);
    wr(32'h206, 32'h2222_2222, 4'h3, 1, 0);
    wait_empty("R2 retire");

    // R3: merge into non-head entries, head never merges
    set_rdy(0);
    wr(32'h300, 32'hAAAA_AAAA, 4'hF, 1, 0);
    wr(32'h400, 32'h0000_00BB, 4'h1, 1, 0);
    wr(32'h401, 32'h0000_CC00, 4'h2, 1, 0);
    wr(32'h400, 32'h0000_00DD, 4'h1, 1, 0);
    wr(32'h300, 32'h1234_5678, 4'h1, 1, 0);
    expm(32'h300, 32'hAAAA_AAAA, 4'hF, 1'b0);
    expm(32'h400, 32'h0000_CCDD, 4'h3, 1'b0);
    expm(32'h300, 32'h1234_5678, 4'h1, 1'b0);
    @(negedge clk);
    chk(req_ready_o === 1'b1, "R3 merge kept a free entry", req_ready_o, 1);
    set_rdy(1);
    wait_empty("R3 merged writes");

    // R4: full queue stalls, merge hit still accepted
    set_rdy(0);
    wr(32'h500, 32'h0505_0505, 4'hF, 1, 1);
    wr(32'h504, 32'h0404_0404, 4'hF, 1, 1);
    wr(32'h508, 32'h0808_0808, 4'hF, 1, 1);
    wr(32'h50C, 32'h0C0C_0C0C, 4'hF, 1, 1);
    @(posedge clk); #1;
    req_valid_i = 1; req_addr_i = 32'h510; req_data_i = 32'h1; req_strb_i = 4'hF;
    req_buf_i = 1; req_cache_i = 1;
    @(negedge clk);
    chk(req_ready_o === 1'b0, "R4 full stall", req_ready_o, 0);
    @(posedge clk); #1;
    req_addr_i = 32'h508; req_data_i = 32'hFF00_0000; req_strb_i = 4'h8;
    @(negedge clk);
    chk(req_ready_o === 1'b1, "R4 merge while full", req_ready_o, 1);
    @(posedge clk); #1;
    req_valid_i = 0;
    expm(32'h500, 32'h0505_0505, 4'hF, 1'b1);
    expm(32'h504, 32'h0404_0404, 4'hF, 1'b1);
    expm(32'h508, 32'hFF08_0808, 4'hF, 1'b1);
    expm(32'h50C, 32'h0C0C_0C0C, 4'hF, 1'b1);
    set_rdy(1);
    wait_empty("R4 drain after full");

    // R5: uncached store waits behind posted writes, never merges
    set_rdy(0);
    expm(32'h600, 32'h6666_6666, 4'hF, 1'b0);
    expm(32'h700, 32'h7777_0001, 4'hF, 1'b0);
    expm(32'h700, 32'h7777_0002, 4'hF, 1'b0);
    wr(32'h600, 32'h6666_6666, 4'hF, 1, 0);
    wr(32'h700, 32'h7777_0001, 4'hF, 0, 0);
    fork
      wr(32'h700, 32'h7777_0002, 4'hF, 0, 0);
      begin
        repeat (3) @(negedge clk);
        chk(req_ready_o === 1'b0, "R5 stall behind uncached", req_ready_o, 0);
        chk(mem_addr_o === 32'h600, "R5 older posted write first", mem_addr_o, 32'h600);
        set_rdy(1);
      end
    join
    wait_empty("R5 order");

    // R6: acceptance-time faults abort and are dropped
    wr(32'h1000_0000, 32'hDEAD_0001, 4'hF, 1, 0);
    @(negedge clk);
    chk(abort_o === 1'b1, "R6 abort on limit", abort_o, 1);
    wr(32'h800, 32'hDEAD_0002, 4'h0, 1, 0);
    @(negedge clk);
    chk(abort_o === 1'b1, "R6 abort on zero strobe", abort_o, 1);
    wr(32'hF000_0000, 32'hDEAD_0003, 4'hF, 0, 0);
    @(negedge clk);
    chk(abort_o === 1'b1, "R6 abort uncached", abort_o, 1);
    expm(32'h804, 32'h0000_0804, 4'hF, 1'b0);
    wr(32'h804, 32'h0000_0804, 4'hF, 1, 0);
    @(negedge clk);
    chk(abort_o === 1'b0, "R6 legal no abort", abort_o, 0);
    wait_empty("R6 dropped writes");

    // R7 R8: memory error raises sticky interrupt
    set_rdy(0);
    expm(32'h900, 32'h0000_0900, 4'hF, 1'b0);
    wr(32'h900, 32'h0000_0900, 4'hF, 1, 0);
    @(posedge clk); #1;
    mem_ready_i = 1; mem_err_i = 1;
    @(posedge clk); #1;
    mem_err_i = 0;
    @(negedge clk);
    chk(irq_o === 1'b1, "R7 irq set", irq_o, 1);
    chk(err_addr_o === 32'h900, "R7 err addr", err_addr_o, 32'h900);
    chk(abort_o === 1'b0, "R7 no abort", abort_o, 0);
    repeat (3) @(negedge clk);
    chk(irq_o === 1'b1, "R8 irq sticky", irq_o, 1);
    @(posedge clk); #1 irq_clr_i = 1;
    @(posedge clk); #1 irq_clr_i = 0;
    @(negedge clk);
    chk(irq_o === 1'b0, "R8 irq cleared", irq_o, 0);
    set_rdy(0);
    expm(32'h904, 32'h0000_0904, 4'hF, 1'b0);
    wr(32'h904, 32'h0000_0904, 4'hF, 1, 0);
    @(posedge clk); #1;
    mem_ready_i = 1; mem_err_i = 1; irq_clr_i = 1;
    @(posedge clk); #1;
    mem_err_i = 0; irq_clr_i = 0;
    @(negedge clk);
    chk(irq_o === 1'b1, "R8 set wins over clear", irq_o, 1);
    chk(err_addr_o === 32'h904, "R7 second err addr", err_addr_o, 32'h904);
    @(posedge clk); #1 irq_clr_i = 1;
    @(posedge clk); #1 irq_clr_i = 0;

    // R9: drain handshake
    set_rdy(0);
    expm(32'hA00, 32'h0000_0A00, 4'hF, 1'b0);
    expm(32'hA04, 32'h0000_0A04, 4'hF, 1'b0);
    wr(32'hA00, 32'h0000_0A00, 4'hF, 1, 0);
    wr(32'hA04, 32'h0000_0A04, 4'hF, 1, 0);
    @(posedge clk); #1 drain_req_i = 1;
    @(negedge clk);
    chk(drain_done_o === 1'b0, "R9 not done while pending", drain_done_o, 0);
    chk(req_ready_o === 1'b0, "R9 stores stalled", req_ready_o, 0);
    set_rdy(1);
    for (int k = 0; k < 10 && !drain_done_o; k++) @(negedge clk);
    chk(drain_done_o === 1'b1, "R9 done", drain_done_o, 1);
    chk(exp_q.size() == 0, "R9 all written at done", exp_q.size(), 0);
    @(posedge clk); #1 drain_req_i = 0;
    @(negedge clk);
    chk(drain_done_o === 1'b0, "R9 done drops with request", drain_done_o, 0);
    chk(req_ready_o === 1'b1, "R9 ready restored", req_ready_o, 1);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule